// File: doc/BRIEF.md
# DDR3 DLL and Termination Command Guard

This block sits between a memory controller's command scheduler and the DRAM command bus. Every command from the scheduler passes through it with a valid/ready handshake. It keeps a copy of the mode-register fields that decide the DLL mode, the termination values and the driver impedance, and it follows the DLL of the device through four states. It holds back any command that needs a locked DLL until the lock interval has run out. It gates the ODT pin and raises error flags for configurations the device cannot support with its DLL switched off.

The DLL state machine has these states (encoding on `dll_state_o`): `DLL_LOCKED` (0), `DLL_RELOCK` (1), `DLL_SELFREF` (2) and `DLL_OFF` (3). It has these transitions:
- reset → `DLL_RELOCK`.
- `DLL_RELOCK` → `DLL_LOCKED` when the down-counter reaches zero.
- `DLL_LOCKED` → `DLL_SELFREF` on self-refresh entry.
- `DLL_SELFREF` → `DLL_RELOCK` on self-refresh exit.
- `DLL_LOCKED`/`DLL_RELOCK` → `DLL_RELOCK` (counter reloaded) on a DLL reset through MR0.
- `DLL_LOCKED`/`DLL_RELOCK` → `DLL_OFF` when MR1 bit 0 is written as 1.
- `DLL_OFF` → `DLL_RELOCK` when MR1 bit 0 is written as 0.

Every entry into `DLL_RELOCK` loads the counter with `TDLLK`-1.

Top module: `ddr3_dll_odt_guard`

## Requirements
- R1: After reset the state is `DLL_RELOCK` (1) and all termination and impedance outputs are zero. The state becomes `DLL_LOCKED` (0) exactly `TDLLK` clock edges after the edge that loaded the counter.
- R2: An accepted MRS (code 1) to bank 1 sets `rtt_nom_o` = {A9,A6,A2} and `drv_imp_o` = {A5,A1}. An accepted MRS to bank 2 sets `rtt_wr_o` = {A10,A9}. The new values appear after the accepting edge.
- R3: A READ (code 2) sees `cmd_ready_o` low in `DLL_RELOCK` and `DLL_SELFREF`. After reset it first sees ready high `TDLLK` cycles after reset release.
- R4: An accepted self-refresh entry (code 4) in `DLL_LOCKED` moves the state to `DLL_SELFREF`. An accepted exit (code 5) moves it to `DLL_RELOCK`, and a READ is then ready again `TDLLK`+1 cycles after the exit was offered.
- R5: An accepted MRS to bank 0 with A8=1 reloads the relock counter. An MRS to bank 1 with A0=0 while in `DLL_OFF` enters `DLL_RELOCK`.
- R6: An MRS to bank 1 with A0=1 moves the state to `DLL_OFF`. In `DLL_OFF` a READ is ready.
- R7: `err_cke_o` is high while a self-refresh entry or power-down entry (code 6) is offered in `DLL_RELOCK`, and low for those commands in `DLL_LOCKED`.
- R8: `err_odt_o` is high in `DLL_OFF` when `odt_req_i` is high and the nominal termination is nonzero. It is low when that termination is 000.
- R9: `err_dyn_odt_o` is high in `DLL_OFF` while the write termination is nonzero, and low once it is 00.
- R10: A WRITE (code 3) is held back in every state except `DLL_LOCKED` when the write termination is nonzero. With write termination 00 a WRITE is ready in `DLL_RELOCK` and `DLL_OFF`.
- R11: While a WRITE is offered with nonzero write termination, `term_wr_o`=1 and `term_code_o`={0,rtt_wr}. For every other command `term_wr_o`=0 and `term_code_o`=rtt_nom.
- R12: `odt_o` follows `odt_req_i` in `DLL_LOCKED` and `DLL_OFF`. It is held low in `DLL_RELOCK` and `DLL_SELFREF`.
- R13: Every accepted command appears on the bus once, unchanged and in order. A held-back command is issued once it is allowed, not dropped. Code 0 is NOP and code 7 is power-down exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Scheduler command valid |
| cmd_ready_o | output | 1 | Guard accepts the offered command |
| cmd_code_i | input | 3 | Command code |
| cmd_ba_i | input | 3 | Bank / mode-register select |
| cmd_addr_i | input | 16 | Address / mode-register value |
| odt_req_i | input | 1 | Scheduler ODT request |
| bus_valid_o | output | 1 | Command issued to DRAM this cycle |
| bus_code_o | output | 3 | Issued command code |
| bus_ba_o | output | 3 | Issued bank |
| bus_addr_o | output | 16 | Issued address |
| odt_o | output | 1 | ODT pin to DRAM |
| dll_state_o | output | 2 | DLL state encoding |
| rtt_nom_o | output | 3 | Nominal termination selection |
| rtt_wr_o | output | 2 | Write termination selection |
| drv_imp_o | output | 2 | Driver impedance selection |
| term_code_o | output | 3 | Termination in force for the offered command |
| term_wr_o | output | 1 | Write termination in force |
| err_cke_o | output | 1 | CKE-low request during relock |
| err_odt_o | output | 1 | Direct ODT used in DLL-off mode |
| err_dyn_odt_o | output | 1 | Write termination set in DLL-off mode |

## Verification
The handshake outputs (ready, bus command, error flags, termination report and ODT gating) are combinational in the current state. They are due in the same cycle as the stimulus, so the bench drives inputs just after a falling edge and samples 1 ns later. Mode-register fields and the DLL state change on the edge that accepts the command. Those checks run at the following falling edge. The lock interval is measured by counting rising edges from the counter-loading edge to the first cycle READ is ready. The result is compared with `TDLLK` or `TDLLK`+1 as the requirement states.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    typedef enum logic [1:0] {
        DLL_LOCKED  = 2'd0,
        DLL_RELOCK  = 2'd1,
        DLL_SELFREF = 2'd2,
        DLL_OFF     = 2'd3
    } dll_state_e;

    localparam logic [2:0] CMD_NOP   = 3'd0;
    localparam logic [2:0] CMD_MRS   = 3'd1;
    localparam logic [2:0] CMD_READ  = 3'd2;
    localparam logic [2:0] CMD_WRITE = 3'd3;
    localparam logic [2:0] CMD_SRE   = 3'd4;
    localparam logic [2:0] CMD_SRX   = 3'd5;
    localparam logic [2:0] CMD_PDE   = 3'd6;
    localparam logic [2:0] CMD_PDX   = 3'd7;

    // picked mode-register bits: {A10,A9,A8,A6,A5,A2,A1,A0}
    typedef struct packed {
        logic a10;
        logic a9;
        logic a8;
        logic a6;
        logic a5;
        logic a2;
        logic a1;
        logic a0;
    } mr_bits_t;

endpackage

// File: rtl/mr_shadow.sv
module mr_shadow
    import ddr_guard_pkg::*;
#(
    parameter int BAW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mrs_acc,
    input  logic [BAW-1:0] ba,
    input  mr_bits_t       bits,
    output logic [2:0]     rtt_nom,
    output logic [1:0]     rtt_wr,
    output logic [1:0]     drv_imp
);
    localparam logic [BAW-1:0] BA_MR1 = BAW'(1);
    localparam logic [BAW-1:0] BA_MR2 = BAW'(2);

    logic wr_mr1, wr_mr2;

    always_comb begin
        wr_mr1 = mrs_acc && (ba == BA_MR1);
        wr_mr2 = mrs_acc && (ba == BA_MR2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rtt_nom <= '0;
            rtt_wr  <= '0;
            drv_imp <= '0;
        end else begin
            if (wr_mr1) begin
                rtt_nom <= {bits.a9, bits.a6, bits.a2};
                drv_imp <= {bits.a5, bits.a1};
            end
            if (wr_mr2) begin
                rtt_wr <= {bits.a10, bits.a9};
            end
        end
    end

    // R2: shadow follows the accepted MR1 / MR2 write
    a_r2_mr1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mr1 |=> (rtt_nom == {$past(bits.a9), $past(bits.a6), $past(bits.a2)}));
    a_r2_mr2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mr2 |=> (rtt_wr == {$past(bits.a10), $past(bits.a9)}));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mrs_acc |=> $stable(rtt_nom) && $stable(rtt_wr) && $stable(drv_imp));

endmodule

// File: rtl/dll_fsm.sv
module dll_fsm
    import ddr_guard_pkg::*;
#(
    parameter int TDLLK = 512,
    parameter int BAW   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc,
    input  logic [2:0]     code,
    input  logic [BAW-1:0] ba,
    input  mr_bits_t       bits,
    output dll_state_e     state_o
);
    localparam int CW = $clog2(TDLLK + 1);
    localparam logic [CW-1:0] RELOAD = CW'(TDLLK - 1);
    localparam logic [BAW-1:0] BA_MR0 = BAW'(0);
    localparam logic [BAW-1:0] BA_MR1 = BAW'(1);

    dll_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic          load;
    logic          ev_reset, ev_dis, ev_en, ev_sre, ev_srx;

    always_comb begin
        ev_reset = acc && code == CMD_MRS && ba == BA_MR0 && bits.a8;
        ev_dis   = acc && code == CMD_MRS && ba == BA_MR1 && bits.a0;
        ev_en    = acc && code == CMD_MRS && ba == BA_MR1 && !bits.a0;
        ev_sre   = acc && code == CMD_SRE;
        ev_srx   = acc && code == CMD_SRX;
    end

    // next-state and counter-load decision
    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            DLL_LOCKED: begin
                if (ev_dis) nxt = DLL_OFF;
                else if (ev_reset) begin nxt = DLL_RELOCK; load = 1'b1; end
                else if (ev_sre) nxt = DLL_SELFREF;
            end
            DLL_RELOCK: begin
                if (ev_dis) nxt = DLL_OFF;
                else if (ev_reset) load = 1'b1;
                else if (cnt == '0) nxt = DLL_LOCKED;
            end
            DLL_SELFREF: begin
                if (ev_srx) begin nxt = DLL_RELOCK; load = 1'b1; end
            end
            DLL_OFF: begin
                if (ev_en) begin nxt = DLL_RELOCK; load = 1'b1; end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DLL_RELOCK;
            cnt   <= RELOAD;
        end else begin
            state <= nxt;
            if (load)
                cnt <= RELOAD;
            else if (state == DLL_RELOCK && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    // outputs
    always_comb begin
        state_o = state;
    end

    // R1: no lock while the interval is still running
    a_r1_no_early_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DLL_RELOCK && cnt != '0) |=> (state != DLL_LOCKED));
    // R1: the interval counts down one per cycle unless reloaded
    a_r1_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DLL_RELOCK && cnt != '0 && !acc) |=> (cnt == $past(cnt) - 1'b1));
    // R4: leaving self-refresh always restarts the relock interval
    a_r4_srx_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DLL_SELFREF && ev_srx) |=> (state == DLL_RELOCK && cnt == RELOAD));
    // R6: a DLL-off write always lands in DLL_OFF
    a_r6_dis_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_dis && state != DLL_SELFREF) |=> (state == DLL_OFF));

endmodule

// File: rtl/cmd_gate.sv
module cmd_gate
    import ddr_guard_pkg::*;
(
    input  dll_state_e state,
    input  logic       cmd_valid,
    input  logic [2:0] code,
    input  logic [2:0] rtt_nom,
    input  logic [1:0] rtt_wr,
    input  logic       odt_req,
    output logic       ready,
    output logic       odt_out,
    output logic       cke_err,
    output logic       odt_err,
    output logic       dyn_err,
    output logic [2:0] term_code,
    output logic       term_wr
);
    logic is_rd, is_wr, wr_term_on, blk;

    always_comb begin
        is_rd      = (code == CMD_READ);
        is_wr      = (code == CMD_WRITE);
        wr_term_on = (rtt_wr != 2'b00);
        blk        = 1'b0;
        odt_out    = 1'b0;
        unique case (state)
            DLL_LOCKED: begin
                blk     = 1'b0;
                odt_out = odt_req;
            end
            DLL_RELOCK, DLL_SELFREF: begin
                blk     = is_rd || (is_wr && wr_term_on);
                odt_out = 1'b0;
            end
            DLL_OFF: begin
                blk     = is_wr && wr_term_on;
                odt_out = odt_req;
            end
        endcase
        ready   = !blk;
        cke_err = cmd_valid && (state == DLL_RELOCK) &&
                  (code == CMD_SRE || code == CMD_PDE);
        odt_err = (state == DLL_OFF) && odt_req && (rtt_nom != 3'b000);
        dyn_err = (state == DLL_OFF) && wr_term_on;
        if (is_wr && wr_term_on) begin
            term_code = {1'b0, rtt_wr};
            term_wr   = 1'b1;
        end else begin
            term_code = rtt_nom;
            term_wr   = 1'b0;
        end
    end

endmodule

// File: rtl/ddr3_dll_odt_guard.sv
module ddr3_dll_odt_guard
    import ddr_guard_pkg::*;
#(
    parameter int TDLLK = 512,
    parameter int AW    = 16,
    parameter int BAW   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid_i,
    output logic           cmd_ready_o,
    input  logic [2:0]     cmd_code_i,
    input  logic [BAW-1:0] cmd_ba_i,
    input  logic [AW-1:0]  cmd_addr_i,
    input  logic           odt_req_i,
    output logic           bus_valid_o,
    output logic [2:0]     bus_code_o,
    output logic [BAW-1:0] bus_ba_o,
    output logic [AW-1:0]  bus_addr_o,
    output logic           odt_o,
    output logic [1:0]     dll_state_o,
    output logic [2:0]     rtt_nom_o,
    output logic [1:0]     rtt_wr_o,
    output logic [1:0]     drv_imp_o,
    output logic [2:0]     term_code_o,
    output logic           term_wr_o,
    output logic           err_cke_o,
    output logic           err_odt_o,
    output logic           err_dyn_odt_o
);
    mr_bits_t   bits;
    dll_state_e state;
    logic       acc;

    always_comb begin
        bits = '{a10: cmd_addr_i[10], a9: cmd_addr_i[9], a8: cmd_addr_i[8],
                 a6: cmd_addr_i[6],  a5: cmd_addr_i[5], a2: cmd_addr_i[2],
                 a1: cmd_addr_i[1],  a0: cmd_addr_i[0]};
        acc         = cmd_valid_i && cmd_ready_o;
        bus_valid_o = acc;
        bus_code_o  = cmd_code_i;
        bus_ba_o    = cmd_ba_i;
        bus_addr_o  = cmd_addr_i;
        dll_state_o = state;
    end

    mr_shadow #(.BAW(BAW)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .mrs_acc (acc && cmd_code_i == CMD_MRS),
        .ba      (cmd_ba_i),
        .bits    (bits),
        .rtt_nom (rtt_nom_o),
        .rtt_wr  (rtt_wr_o),
        .drv_imp (drv_imp_o)
    );

    dll_fsm #(.TDLLK(TDLLK), .BAW(BAW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .code    (cmd_code_i),
        .ba      (cmd_ba_i),
        .bits    (bits),
        .state_o (state)
    );

    cmd_gate u_gate (
        .state     (state),
        .cmd_valid (cmd_valid_i),
        .code      (cmd_code_i),
        .rtt_nom   (rtt_nom_o),
        .rtt_wr    (rtt_wr_o),
        .odt_req   (odt_req_i),
        .ready     (cmd_ready_o),
        .odt_out   (odt_o),
        .cke_err   (err_cke_o),
        .odt_err   (err_odt_o),
        .dyn_err   (err_dyn_odt_o),
        .term_code (term_code_o),
        .term_wr   (term_wr_o)
    );

    // R3: no READ reaches the bus while the DLL is relocking or in self-refresh
    a_r3_read_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && bus_code_o == CMD_READ) |->
            (state == DLL_LOCKED || state == DLL_OFF));
    // R10: a write with write termination set only issues with a locked DLL
    a_r10_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && bus_code_o == CMD_WRITE && rtt_wr_o != 2'b00) |->
            (state == DLL_LOCKED));
    // R12: ODT pin never rises without a request and never during relock
    a_r12_odt_gate: assert property (@(posedge clk) disable iff (!rst_n)
        odt_o |-> (odt_req_i && state != DLL_RELOCK && state != DLL_SELFREF));
    // R13: a held-back command never appears on the bus
    a_r13_no_issue_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready_o |-> !bus_valid_o);

endmodule

// File: tb/sim_ddr3_dll_odt_guard.sv
module sim_ddr3_dll_odt_guard;
    localparam int TDLLK = 20;
    localparam logic [2:0] C_MRS = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                           C_SRE = 3'd4, C_SRX = 3'd5, C_PDE = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid_i = 1'b0;
    logic [2:0]  cmd_code_i = '0;
    logic [2:0]  cmd_ba_i = '0;
    logic [15:0] cmd_addr_i = '0;
    logic        odt_req_i = 1'b0;
    logic        cmd_ready_o, bus_valid_o, odt_o, term_wr_o;
    logic        err_cke_o, err_odt_o, err_dyn_odt_o;
    logic [2:0]  bus_code_o, bus_ba_o, rtt_nom_o, term_code_o;
    logic [15:0] bus_addr_o;
    logic [1:0]  dll_state_o, rtt_wr_o, drv_imp_o;

    ddr3_dll_odt_guard #(.TDLLK(TDLLK)) u0 (.*);

    always #5 clk = ~clk;

    int vectors = 0, misses = 0, cyc = 0;
    logic [21:0] expq[$];
    int acc_cyc;
    logic pk_rdy, pk_cke, acc_twr;
    logic [2:0] acc_tcode;

    initial forever begin @(posedge clk); cyc++; end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: every issued command must match the next queued item
    initial forever begin
        @(negedge clk); #4;
        if (rst_n && bus_valid_o) begin
            if (expq.size() == 0) begin
                chk("R13 unexpected issue", 1, 0);
            end else begin
                logic [21:0] e;
                e = expq.pop_front();
                chk("R13 issued command", int'({bus_ba_o, bus_code_o, bus_addr_o}), int'(e));
            end
        end
    end

    task automatic send(input logic [2:0] c, input logic [2:0] b, input logic [15:0] a);
        @(negedge clk);
        cmd_code_i = c; cmd_ba_i = b; cmd_addr_i = a; cmd_valid_i = 1'b1;
        #1;
        while (!cmd_ready_o) begin @(negedge clk); #1; end
        acc_cyc = cyc; acc_twr = term_wr_o; acc_tcode = term_code_o;
        expq.push_back({b, c, a});
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic peek(input logic [2:0] c, input logic [2:0] b, input logic [15:0] a);
        @(negedge clk);
        cmd_code_i = c; cmd_ba_i = b; cmd_addr_i = a; cmd_valid_i = 1'b1;
        #1;
        pk_rdy = cmd_ready_o; pk_cke = err_cke_o;
        cmd_valid_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        #1_000_000;
        misses++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        int rel, s, m;
        odt_req_i = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset state", dll_state_o, 1);
        chk("R1 reset rtt_nom", rtt_nom_o, 0);
        chk("R1 reset rtt_wr", rtt_wr_o, 0);
        chk("R1 reset drv_imp", drv_imp_o, 0);
        chk("R12 odt low in relock", odt_o, 0);
        @(negedge clk);
        rst_n = 1'b1; odt_req_i = 1'b0;
        rel = cyc;
        peek(C_PDE, 0, 0);
        chk("R7 cke-low in relock", pk_cke, 1);
        peek(C_WR, 0, 0);
        chk("R10 write no rtt_wr in relock", pk_rdy, 1);
        send(C_RD, 0, 16'h0040);
        chk("R3 read wait after reset", acc_cyc - rel, TDLLK);
        chk("R1 locked", dll_state_o, 0);
        odt_req_i = 1'b1; #1;
        chk("R12 odt follows when locked", odt_o, 1);
        odt_req_i = 1'b0;
        peek(C_PDE, 0, 0);
        chk("R7 cke-low when locked", pk_cke, 0);
        send(C_MRS, 1, 16'h0206);
        chk("R2 rtt_nom", rtt_nom_o, 5);
        chk("R2 drv_imp", drv_imp_o, 1);
        send(C_MRS, 2, 16'h0200);
        chk("R2 rtt_wr", rtt_wr_o, 1);
        send(C_WR, 0, 16'h0010);
        chk("R11 write term flag", acc_twr, 1);
        chk("R11 write term code", acc_tcode, 1);
        send(C_RD, 0, 16'h0020);
        chk("R11 read term flag", acc_twr, 0);
        chk("R11 read term code", acc_tcode, 5);
        send(C_SRE, 0, 0);
        chk("R4 selfref state", dll_state_o, 2);
        peek(C_RD, 0, 0);
        chk("R3 read held in selfref", pk_rdy, 0);
        odt_req_i = 1'b1; #1;
        chk("R12 odt low in selfref", odt_o, 0);
        odt_req_i = 1'b0;
        send(C_SRX, 0, 0);
        s = acc_cyc;
        chk("R4 relock after exit", dll_state_o, 1);
        peek(C_WR, 0, 0);
        chk("R10 write held with rtt_wr", pk_rdy, 0);
        send(C_RD, 0, 16'h0080);
        chk("R4 read wait after exit", acc_cyc - s, TDLLK + 1);
        send(C_MRS, 1, 16'h0005);
        chk("R6 dll off state", dll_state_o, 3);
        odt_req_i = 1'b1; #1;
        chk("R8 odt error", err_odt_o, 1);
        chk("R9 dyn odt error", err_dyn_odt_o, 1);
        odt_req_i = 1'b0;
        peek(C_RD, 0, 0);
        chk("R6 read ready in dll off", pk_rdy, 1);
        peek(C_WR, 0, 0);
        chk("R10 write held in dll off", pk_rdy, 0);
        send(C_MRS, 2, 16'h0000);
        #1;
        chk("R9 dyn error cleared", err_dyn_odt_o, 0);
        peek(C_WR, 0, 0);
        chk("R10 write ready rtt_wr 0", pk_rdy, 1);
        send(C_MRS, 1, 16'h0001);
        odt_req_i = 1'b1; #1;
        chk("R8 odt error cleared", err_odt_o, 0);
        chk("R12 odt follows in dll off", odt_o, 1);
        odt_req_i = 1'b0;
        send(C_MRS, 1, 16'h0000);
        chk("R5 enable relocks", dll_state_o, 1);
        repeat (5) @(negedge clk);
        send(C_MRS, 0, 16'h0100);
        m = acc_cyc;
        send(C_RD, 0, 16'h0100);
        chk("R5 read wait after dll reset", acc_cyc - m, TDLLK + 1);
        repeat (3) @(negedge clk);
        chk("R13 all commands issued", expq.size(), 0);
        finish_run();
    end
endmodule